// File: doc/BRIEF.md
# Dual-Line Programmable Interrupt Controller

The block gathers up to 32 raw interrupt lines from peripherals and turns them into two request lines toward a processor core. Each source line has its own trigger mode. The mode is a three-bit code held across three separate configuration planes, so that software can set or clear one bit of one source without a read-modify-write. The modes are disabled, rising edge, falling edge, either edge, level high and level low. A detected edge is held in a rising or a falling capture latch until software acknowledges it. A level source follows its synchronised input.

A mask plane enables each source. A routing plane sends each enabled source either to the high-priority request line (routing bit one) or to the low-priority line (routing bit zero). There are also a source-select plane and a wake-enable plane, which are plain storage. Every plane has a set address and a clear address. Writing ones to the set address sets those bits, writing ones to the clear address clears them, and zero bits change nothing. A plane reads back on its set address. Two read-only views return the pending vector of each request line. Software polls these views to find which sources need service.

Top module: `irqc_dual_line`

## Requirements
- R1: After reset, every configuration, mask, routing and wake plane, both capture latches and the test word read as zero, the source-select plane reads all ones, and both request outputs are low.
- R2: A write to a plane's set address (0x40 + 8·p for plane p: cfg0, cfg1, cfg2, source, route, wake, mask) ORs the one bits of the write data into the plane. A write to its clear address (set + 4) clears the bits that are one. Zero bits leave the plane unchanged. The plane reads back at its set address.
- R3: Mode {cfg2,cfg1,cfg0} = 001 latches a rising input edge into the rising latch (read at 0x78) within three cycles and never latches a falling edge.
- R4: Mode 010 latches a falling input edge into the falling latch (read at 0x7C) and never latches a rising edge.
- R5: Mode 011 latches rising edges into the rising latch and falling edges into the falling latch.
- R6: In mode 101 a source is active while its input is high. In mode 110 it is active while its input is low. Both take effect within three cycles, and neither mode sets a capture latch.
- R7: Mode 000 and the unused codes 100 and 111 never make a source active and never set a capture latch.
- R8: A source drives no request and no pending bit while its mask bit is zero.
- R9: An active, unmasked source with routing bit 1 appears at 0x54 and raises `req0_o`. With routing bit 0 it appears at 0x5C and raises `req1_o`. Each request output is the OR of its pending vector.
- R10: An edge-mode source stays pending until a one is written to its bit at 0x78 or 0x7C. Zero bits written there clear nothing.
- R11: When a new enabled edge is detected in the same cycle that software clears the matching latch bit, the latch bit ends up set.
- R12: Read data appears one cycle after a read strobe and is zero in any cycle that follows no read. Unmapped addresses, including the clear-only addresses 0x44, 0x4C, 0x64, 0x6C and 0x74, read as zero.
- R13: The test word at 0x80 stores a full written word, reads it back, and resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_i | input | NSRC | Raw asynchronous interrupt lines |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Registered read data |
| req0_o | output | 1 | High-priority request line |
| req1_o | output | 1 | Low-priority request line |

## Verification
On every cycle, the checker confirms these properties: a request line is only ever high when some source is unmasked and routed to it; writes to the mask set and clear addresses take effect on the next cycle; a capture latch bit can only rise when its mode allows that edge; an acknowledged latch bit is only set again if an enabled edge arrived in the same cycle; and read data is zero after any idle cycle. The bench scenarios are needed for the behaviour that depends on a sequence of events. That covers the per-mode reaction to real input waveforms through the synchroniser, the holding of edge requests until acknowledge, and level tracking in both polarities. It also covers the reset contents, the routing of pending bits to the two read views, and the precise collision of an acknowledge with a fresh edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Register planes, in address order; the index sets the set address.
   localparam int NPLANE       = 7;
   localparam int PL_CFG0      = 0;
   localparam int PL_CFG1      = 1;
   localparam int PL_CFG2      = 2;
   localparam int PL_SRC       = 3;
   localparam int PL_ROUTE     = 4;
   localparam int PL_WAKE      = 5;
   localparam int PL_MASK      = 6;

   localparam int PLANE_BASE   = 'h40;
   localparam int PLANE_STRIDE = 8;
   localparam int PLANE_CLR    = 4;

   localparam int PEND0_ADDR   = 'h54;
   localparam int PEND1_ADDR   = 'h5C;
   localparam int RISE_ADDR    = 'h78;
   localparam int FALL_ADDR    = 'h7C;
   localparam int TEST_ADDR    = 'h80;

   // Trigger code {cfg2,cfg1,cfg0}
   typedef enum logic [2:0] {
      TRIG_OFF  = 3'b000,
      TRIG_RISE = 3'b001,
      TRIG_FALL = 3'b010,
      TRIG_ANY  = 3'b011,
      TRIG_HIGH = 3'b101,
      TRIG_LOW  = 3'b110
   } trig_e;

   function automatic int plane_set_addr(int p);
      return PLANE_BASE + PLANE_STRIDE * p;
   endfunction

endpackage

// File: rtl/irqc_sc_plane.sv
module irqc_sc_plane #(
   parameter int W        = 32,
   parameter bit RST_ONES = 1'b0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         set_i,
   input  logic         clr_i,
   input  logic [W-1:0] bits_i,
   output logic [W-1:0] q_o
);

   localparam logic [W-1:0] RST_VAL = RST_ONES ? {W{1'b1}} : {W{1'b0}};

   logic [W-1:0] set_bits;
   logic [W-1:0] clr_bits;

   assign set_bits = set_i ? bits_i : '0;
   assign clr_bits = clr_i ? bits_i : '0;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         q_o <= RST_VAL;
      end else begin
         q_o <= (q_o | set_bits) & ~clr_bits;
      end
   end

endmodule

// File: rtl/irqc_edge_unit.sv
module irqc_edge_unit #(
   parameter int NSRC        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] irq_i,
   input  logic [NSRC-1:0] rise_en_i,
   input  logic [NSRC-1:0] fall_en_i,
   input  logic [NSRC-1:0] rise_clr_i,
   input  logic [NSRC-1:0] fall_clr_i,
   output logic [NSRC-1:0] lvl_o,
   output logic [NSRC-1:0] rise_evt_o,
   output logic [NSRC-1:0] fall_evt_o,
   output logic [NSRC-1:0] rise_lat_o,
   output logic [NSRC-1:0] fall_lat_o
);

   logic [SYNC_STAGES-1:0][NSRC-1:0] chain;
   logic [NSRC-1:0]                  prev_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         chain  <= '0;
         prev_q <= '0;
      end else begin
         chain[0] <= irq_i;
         for (int k = 1; k < SYNC_STAGES; k++) begin
            chain[k] <= chain[k-1];
         end
         prev_q <= chain[SYNC_STAGES-1];
      end
   end

   assign lvl_o      = chain[SYNC_STAGES-1];
   assign rise_evt_o = lvl_o & ~prev_q;
   assign fall_evt_o = ~lvl_o & prev_q;

   // An enabled edge in the same cycle as its clear survives.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rise_lat_o <= '0;
         fall_lat_o <= '0;
      end else begin
         rise_lat_o <= (rise_lat_o & ~rise_clr_i) | (rise_evt_o & rise_en_i);
         fall_lat_o <= (fall_lat_o & ~fall_clr_i) | (fall_evt_o & fall_en_i);
      end
   end

endmodule

// File: rtl/irqc_route.sv
module irqc_route
   import irqc_pkg::*;
#(
   parameter int NSRC = 32
) (
   input  logic [NSRC-1:0] cfg0_i,
   input  logic [NSRC-1:0] cfg1_i,
   input  logic [NSRC-1:0] cfg2_i,
   input  logic [NSRC-1:0] lvl_i,
   input  logic [NSRC-1:0] rise_lat_i,
   input  logic [NSRC-1:0] fall_lat_i,
   input  logic [NSRC-1:0] mask_i,
   input  logic [NSRC-1:0] route_i,
   output logic [NSRC-1:0] rise_en_o,
   output logic [NSRC-1:0] fall_en_o,
   output logic [NSRC-1:0] pend0_o,
   output logic [NSRC-1:0] pend1_o
);

   logic [NSRC-1:0] active;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic [2:0] mode;
      assign mode = {cfg2_i[i], cfg1_i[i], cfg0_i[i]};

      always_comb begin
         rise_en_o[i] = 1'b0;
         fall_en_o[i] = 1'b0;
         active[i]    = 1'b0;
         case (mode)
            TRIG_RISE: begin
               rise_en_o[i] = 1'b1;
               active[i]    = rise_lat_i[i] | fall_lat_i[i];
            end
            TRIG_FALL: begin
               fall_en_o[i] = 1'b1;
               active[i]    = rise_lat_i[i] | fall_lat_i[i];
            end
            TRIG_ANY: begin
               rise_en_o[i] = 1'b1;
               fall_en_o[i] = 1'b1;
               active[i]    = rise_lat_i[i] | fall_lat_i[i];
            end
            TRIG_HIGH: active[i] = lvl_i[i];
            TRIG_LOW:  active[i] = ~lvl_i[i];
            default:   active[i] = 1'b0;
         endcase
      end
   end

   assign pend0_o = active & mask_i & route_i;
   assign pend1_o = active & mask_i & ~route_i;

endmodule

// File: rtl/irqc_dual_line.sv
module irqc_dual_line
   import irqc_pkg::*;
#(
   parameter int NSRC        = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NSRC-1:0]   irq_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              req0_o,
   output logic              req1_o
);

   localparam logic [ADDR_W-1:0] A_PEND0 = ADDR_W'(PEND0_ADDR);
   localparam logic [ADDR_W-1:0] A_PEND1 = ADDR_W'(PEND1_ADDR);
   localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(RISE_ADDR);
   localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(FALL_ADDR);
   localparam logic [ADDR_W-1:0] A_TEST  = ADDR_W'(TEST_ADDR);

   if (NSRC < 1 || NSRC > DATA_W) begin : g_bad_nsrc
      $error("NSRC must lie between 1 and DATA_W");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8 to reach the register map");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic [NPLANE-1:0][NSRC-1:0] plane_q;
   logic [NSRC-1:0]             wbits;
   logic [NSRC-1:0]             mask_q;
   logic [NSRC-1:0]             route_q;
   logic [NSRC-1:0]             lvl;
   logic [NSRC-1:0]             rise_evt;
   logic [NSRC-1:0]             fall_evt;
   logic [NSRC-1:0]             rise_lat;
   logic [NSRC-1:0]             fall_lat;
   logic [NSRC-1:0]             rise_en;
   logic [NSRC-1:0]             fall_en;
   logic [NSRC-1:0]             rise_clr;
   logic [NSRC-1:0]             fall_clr;
   logic [NSRC-1:0]             pend0;
   logic [NSRC-1:0]             pend1;
   logic [DATA_W-1:0]           test_q;
   logic [DATA_W-1:0]           rd_val;

   assign wbits = wdata_i[NSRC-1:0];

   // Set/clear planes; addresses follow from the plane index
   for (genvar p = 0; p < NPLANE; p++) begin : g_plane
      localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(plane_set_addr(p));
      localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(plane_set_addr(p) + PLANE_CLR);

      irqc_sc_plane #(
         .W        (NSRC),
         .RST_ONES (p == PL_SRC)
      ) u_plane (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .set_i  (wr_en_i && (addr_i == SET_A)),
         .clr_i  (wr_en_i && (addr_i == CLR_A)),
         .bits_i (wbits),
         .q_o    (plane_q[p])
      );
   end

   assign mask_q  = plane_q[PL_MASK];
   assign route_q = plane_q[PL_ROUTE];

   assign rise_clr = (wr_en_i && (addr_i == A_RISE)) ? wbits : '0;
   assign fall_clr = (wr_en_i && (addr_i == A_FALL)) ? wbits : '0;

   irqc_edge_unit #(
      .NSRC        (NSRC),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .irq_i      (irq_i),
      .rise_en_i  (rise_en),
      .fall_en_i  (fall_en),
      .rise_clr_i (rise_clr),
      .fall_clr_i (fall_clr),
      .lvl_o      (lvl),
      .rise_evt_o (rise_evt),
      .fall_evt_o (fall_evt),
      .rise_lat_o (rise_lat),
      .fall_lat_o (fall_lat)
   );

   irqc_route #(
      .NSRC (NSRC)
   ) u_route (
      .cfg0_i     (plane_q[PL_CFG0]),
      .cfg1_i     (plane_q[PL_CFG1]),
      .cfg2_i     (plane_q[PL_CFG2]),
      .lvl_i      (lvl),
      .rise_lat_i (rise_lat),
      .fall_lat_i (fall_lat),
      .mask_i     (mask_q),
      .route_i    (route_q),
      .rise_en_o  (rise_en),
      .fall_en_o  (fall_en),
      .pend0_o    (pend0),
      .pend1_o    (pend1)
   );

   assign req0_o = |pend0;
   assign req1_o = |pend1;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         test_q <= '0;
      end else if (wr_en_i && (addr_i == A_TEST)) begin
         test_q <= wdata_i;
      end
   end

   always_comb begin
      rd_val = '0;
      for (int p = 0; p < NPLANE; p++) begin
         if (addr_i == ADDR_W'(plane_set_addr(p))) begin
            rd_val[NSRC-1:0] = plane_q[p];
         end
      end
      if (addr_i == A_PEND0) rd_val[NSRC-1:0] = pend0;
      if (addr_i == A_PEND1) rd_val[NSRC-1:0] = pend1;
      if (addr_i == A_RISE)  rd_val[NSRC-1:0] = rise_lat;
      if (addr_i == A_FALL)  rd_val[NSRC-1:0] = fall_lat;
      if (addr_i == A_TEST)  rd_val = test_q;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rdata_o <= '0;
      end else begin
         rdata_o <= rd_en_i ? rd_val : '0;
      end
   end

endmodule

// File: rtl/irqc_dual_line_chk.sv
module irqc_dual_line_chk
   import irqc_pkg::*;
#(
   parameter int NSRC   = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [ADDR_W-1:0] addr_i,
   input logic              wr_en_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic              rd_en_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              req0_o,
   input logic              req1_o,
   input logic [NSRC-1:0]   mask_q,
   input logic [NSRC-1:0]   route_q,
   input logic [NSRC-1:0]   rise_lat,
   input logic [NSRC-1:0]   rise_evt,
   input logic [NSRC-1:0]   rise_en
);

   localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(plane_set_addr(PL_MASK));
   localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(plane_set_addr(PL_MASK) + PLANE_CLR);
   localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(RISE_ADDR);

   assert_idle_rdata_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> (rdata_o == '0));

   assert_mask_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_MSET) |=>
      ((mask_q & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0])));

   assert_mask_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_MCLR) |=> ((mask_q & $past(wdata_i[NSRC-1:0])) == '0));

   assert_rise_gated_by_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((rise_lat & ~$past(rise_lat) & ~$past(rise_en)) == '0));

   assert_ack_only_loses_to_edge_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_RISE) |=>
      ((rise_lat & $past(wdata_i[NSRC-1:0]) & ~$past(rise_evt & rise_en)) == '0));

   assert_req0_needs_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req0_o |-> |(mask_q & route_q));

   assert_req1_needs_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req1_o |-> |(mask_q & ~route_q));

endmodule

bind irqc_dual_line irqc_dual_line_chk #(
   .NSRC   (NSRC),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) i_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .addr_i   (addr_i),
   .wr_en_i  (wr_en_i),
   .wdata_i  (wdata_i),
   .rd_en_i  (rd_en_i),
   .rdata_o  (rdata_o),
   .req0_o   (req0_o),
   .req1_o   (req1_o),
   .mask_q   (mask_q),
   .route_q  (route_q),
   .rise_lat (rise_lat),
   .rise_evt (rise_evt),
   .rise_en  (rise_en)
);

// File: tb/test_irqc_dual_line.sv
module test_irqc_dual_line;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq = '0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rdata;
   logic        req0;
   logic        req1;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   typedef struct {
      string       tag;
      logic [7:0]  a;
      logic [31:0] exp;
   } exp_t;

   exp_t sb_q[$];
   logic rd_d = 1'b0;

   always #4 clk = ~clk;

   irqc_dual_line i_irqc_dual_line (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .irq_i   (irq),
      .addr_i  (addr),
      .wr_en_i (wr_en),
      .wdata_i (wdata),
      .rd_en_i (rd_en),
      .rdata_o (rdata),
      .req0_o  (req0),
      .req1_o  (req1)
   );

   // Monitor: read data is valid the cycle after the strobe
   always @(posedge clk) rd_d <= rd_en;

   always @(negedge clk) begin
      exp_t e;
      if (rd_d) begin
         checks++;
         if (sb_q.size() == 0) begin
            failures++;
            $display("FAIL scoreboard: read data with no expected item");
         end else begin
            e = sb_q.pop_front();
            if (rdata !== e.exp) begin
               failures++;
               $display("FAIL %s: addr 0x%02h actual 0x%08h expected 0x%08h",
                        e.tag, e.a, rdata, e.exp);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      exp_t item;
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      item.tag = tag; item.a = a; item.exp = e;
      sb_q.push_back(item);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] e);
      checks++;
      if (act !== e) begin
         failures++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, e);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // cfg planes: set at 0x40/0x48/0x50, clear at +4
   task automatic set_mode(input int src, input logic [2:0] code);
      for (int b = 0; b < 3; b++) begin
         if (code[b]) wr(8'(8'h40 + 8 * b), 32'(1) << src);
         else         wr(8'(8'h44 + 8 * b), 32'(1) << src);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not complete");
         finish_run();
      end
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);

      // R1 reset state
      chk("R1 req0", {31'b0, req0}, 32'h0);
      chk("R1 req1", {31'b0, req1}, 32'h0);
      rd(8'h40, 32'h0, "R1 cfg0");
      rd(8'h50, 32'h0, "R1 cfg2");
      rd(8'h58, 32'hFFFF_FFFF, "R1 source");
      rd(8'h60, 32'h0, "R1 route");
      rd(8'h70, 32'h0, "R1 mask");
      rd(8'h78, 32'h0, "R1 rise latch");
      rd(8'h80, 32'h0, "R1 test");

      // R2 set/clear semantics
      wr(8'h70, 32'h0000_00F0);
      wr(8'h70, 32'h0000_0300);
      rd(8'h70, 32'h0000_03F0, "R2 mask set OR");
      wr(8'h74, 32'h0000_0110);
      rd(8'h70, 32'h0000_02E0, "R2 mask clear");
      wr(8'h68, 32'h0000_00A5);
      rd(8'h68, 32'h0000_00A5, "R2 wake");
      wr(8'h5C, 32'h0000_FFFF);
      rd(8'h58, 32'hFFFF_0000, "R2 source clear");
      wr(8'h74, 32'hFFFF_FFFF);

      // R12 read timing and unmapped reads
      rd(8'h44, 32'h0, "R12 clear-only addr");
      rd(8'h90, 32'h0, "R12 unmapped");
      wait_cyc(1);
      chk("R12 idle rdata", rdata, 32'h0);

      // R13 test word
      wr(8'h80, 32'h1234_5678);
      rd(8'h80, 32'h1234_5678, "R13 test word");

      // R3 rising edge, source 0 routed to line 0
      set_mode(0, 3'b001);
      wr(8'h70, 32'h1);
      wr(8'h60, 32'h1);
      irq[0] = 1'b1;
      wait_cyc(4);
      chk("R3 req0 after rise", {31'b0, req0}, 32'h1);
      chk("R9 req1 idle", {31'b0, req1}, 32'h0);
      rd(8'h78, 32'h1, "R3 rise latch");
      rd(8'h54, 32'h1, "R9 pending line0");
      rd(8'h5C, 32'h0, "R9 pending line1");
      irq[0] = 1'b0;
      wait_cyc(4);
      chk("R10 held after input low", {31'b0, req0}, 32'h1);
      rd(8'h7C, 32'h0, "R3 no fall latch");
      wr(8'h78, 32'h0);
      rd(8'h78, 32'h1, "R10 zero write keeps");
      wr(8'h78, 32'h1);
      chk("R10 req0 after ack", {31'b0, req0}, 32'h0);
      rd(8'h78, 32'h0, "R10 latch cleared");

      // R4 falling edge, source 1 routed to line 1
      set_mode(1, 3'b010);
      wr(8'h70, 32'h2);
      irq[1] = 1'b1;
      wait_cyc(4);
      chk("R4 no req on rise", {31'b0, req1}, 32'h0);
      rd(8'h78, 32'h0, "R4 no rise latch");
      irq[1] = 1'b0;
      wait_cyc(4);
      chk("R4 req1 after fall", {31'b0, req1}, 32'h1);
      rd(8'h7C, 32'h2, "R4 fall latch");
      rd(8'h5C, 32'h2, "R9 pending line1");
      rd(8'h54, 32'h0, "R9 line0 empty");
      wr(8'h7C, 32'h2);
      chk("R10 req1 after ack", {31'b0, req1}, 32'h0);

      // R5 either edge, source 2
      set_mode(2, 3'b011);
      wr(8'h70, 32'h4);
      irq[2] = 1'b1;
      wait_cyc(4);
      rd(8'h78, 32'h4, "R5 rise latched");
      wr(8'h78, 32'h4);
      irq[2] = 1'b0;
      wait_cyc(4);
      rd(8'h7C, 32'h4, "R5 fall latched");
      chk("R5 req1", {31'b0, req1}, 32'h1);
      wr(8'h7C, 32'h4);

      // R6 level high (src 4, line 0) and level low (src 5, line 1)
      set_mode(4, 3'b101);
      wr(8'h70, 32'h10);
      wr(8'h60, 32'h10);
      irq[4] = 1'b1;
      wait_cyc(3);
      chk("R6 level high active", {31'b0, req0}, 32'h1);
      irq[4] = 1'b0;
      wait_cyc(3);
      chk("R6 level high released", {31'b0, req0}, 32'h0);
      rd(8'h78, 32'h0, "R6 no latch in level mode");
      set_mode(5, 3'b110);
      wr(8'h70, 32'h20);
      chk("R6 level low active", {31'b0, req1}, 32'h1);
      irq[5] = 1'b1;
      wait_cyc(3);
      chk("R6 level low released", {31'b0, req1}, 32'h0);

      // R7 disabled and unused codes
      wr(8'h70, 32'hC0);
      wr(8'h60, 32'hC0);
      set_mode(7, 3'b100);
      irq[6] = 1'b1; irq[7] = 1'b1;
      wait_cyc(4);
      chk("R7 no req while high", {31'b0, req0}, 32'h0);
      irq[6] = 1'b0; irq[7] = 1'b0;
      wait_cyc(4);
      chk("R7 no req after toggle", {31'b0, req0}, 32'h0);
      rd(8'h78, 32'h0, "R7 no rise latch");
      rd(8'h7C, 32'h0, "R7 no fall latch");

      // R8 mask gating, source 8 level high on line 0
      set_mode(8, 3'b101);
      wr(8'h60, 32'h100);
      irq[8] = 1'b1;
      wait_cyc(4);
      chk("R8 masked no req", {31'b0, req0}, 32'h0);
      rd(8'h54, 32'h0, "R8 masked no pending");
      wr(8'h70, 32'h100);
      chk("R8 unmasked req", {31'b0, req0}, 32'h1);
      rd(8'h54, 32'h100, "R8 pending after unmask");

      // R9 reroute to line 1
      wr(8'h64, 32'h100);
      chk("R9 line0 after reroute", {31'b0, req0}, 32'h0);
      chk("R9 line1 after reroute", {31'b0, req1}, 32'h1);
      rd(8'h5C, 32'h100, "R9 pending line1 reroute");
      wr(8'h74, 32'h100);
      irq[8] = 1'b0;

      // R11 ack colliding with a new rising edge, source 3
      set_mode(3, 3'b001);
      wr(8'h70, 32'h8);
      wr(8'h60, 32'h8);
      irq[3] = 1'b1;
      wait_cyc(4);
      irq[3] = 1'b0;
      wait_cyc(4);
      @(negedge clk);
      irq[3] = 1'b1;
      @(negedge clk);
      wr(8'h78, 32'h8);
      rd(8'h78, 32'h8, "R11 edge beats clear");
      chk("R11 req0 stays", {31'b0, req0}, 32'h1);
      wr(8'h78, 32'h8);
      rd(8'h78, 32'h0, "R11 clear without edge");

      wait_cyc(3);
      chk("scoreboard drained", 32'(sb_q.size()), 32'h0);
      done = 1'b1;
      finish_run();
   end

endmodule